// File: doc/BRIEF.md
# SMBus Byte-Access Register Slave

This block is the slave end of a two-wire serial management bus. It oversamples the clock line (SCL) and the data line (SDA) with the system clock. It recognises start, repeated start and stop conditions, compares the received 7-bit device address with the `dev_addr` input, and then gives the bus master single-byte access to an external bank of configuration bytes. The command byte that follows the address carries two fields. Its top bit requests byte access, and its lower seven bits name the byte offset in the bank.

In a write, the master sends a data byte after the command. Once that byte has been acknowledged, the slave issues a one-cycle write strobe together with the offset and the data. In a read, the master sends a repeated start after the command, then sends the address again with the read bit set. When that address is acknowledged, the slave raises a one-cycle read request. It captures `reg_rd_data` one clock later and shifts that byte out, most significant bit first. The master ends the read with a not-acknowledge and a stop. The slave only ever pulls SDA low or releases it, and it changes SDA only while SCL is low.

The controller is a single state machine with these states:

- IDLE: waiting for a start.
- ADDR: receiving the address byte.
- ADDR_ACK: address acknowledge slot.
- CMD: receiving the command byte.
- CMD_ACK: command acknowledge slot.
- DATA: receiving the data byte.
- DATA_ACK: data acknowledge slot.
- TX: sending the read byte.
- TX_ACK: the master's answer slot.
- HOLD: staying off the bus until the next start or stop.

Transitions:

- A stop moves every state to IDLE.
- A start or repeated start moves every state to ADDR.
- ADDR goes to ADDR_ACK when the address is accepted, and to HOLD when it is not.
- ADDR_ACK goes to CMD for a write and to TX for a read.
- CMD goes to CMD_ACK, and CMD_ACK goes to DATA.
- DATA goes to DATA_ACK, and DATA_ACK goes to HOLD.
- TX goes to TX_ACK, and TX_ACK goes to HOLD.

Each move into an acknowledge slot happens on the SCL falling edge after the eighth bit. Each move out of an acknowledge slot happens on the SCL falling edge that ends the slot. TX_ACK ends on the SCL rising edge of the master's answer bit.

Top module: `smb_byte_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and neither `reg_wr_stb` nor `reg_rd_req` is asserted.
- R2: The address byte is received MSB first, with the read/write bit last (1 = read). When the 7-bit address equals `dev_addr`, the slave pulls SDA low in the ninth bit slot. When it does not match, the slave acknowledges nothing in that transaction and makes no register access.
- R3: When a write transaction carries a command with bit 7 = 1, the slave acknowledges the command byte and the data byte. After the data acknowledge slot ends, it pulses `reg_wr_stb` for exactly one cycle, with `reg_off` equal to command bits [6:0] and `reg_wr_data` equal to the data byte.
- R4: A command byte with bit 7 = 0 is acknowledged, and so is the data byte that follows it, but no write strobe is produced.
- R5: After a byte command, a repeated start and a matching address with the read bit at 1 are acknowledged. During that acknowledge the slave pulses `reg_rd_req` for one cycle, with `reg_off` equal to command bits [6:0]. It captures `reg_rd_data` on the following cycle and sends that byte MSB first.
- R6: A read address that is not preceded, in the same transaction, by a command with bit 7 = 1 is not acknowledged, and no read request is issued.
- R7: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R8: A stop condition returns the slave to IDLE from any state and discards a partly received byte. A start condition restarts the address phase from any state.
- R9: After the data byte of a write, any further byte is not acknowledged and causes no further write strobe.
- R10: `reg_wr_stb` and `reg_rd_req` each last one cycle, and they are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Device address the slave answers to |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_off | output | 7 | Byte offset taken from the command byte |
| reg_wr_stb | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Data byte to be written |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_data | input | 8 | Register byte, valid the cycle after `reg_rd_req` |

## Verification
In a read, one SCL falling edge does two jobs. It ends the slave's own acknowledge of the read address, and the slave must at once put the first bit of the register byte on SDA. The line either stays low or is released in that same cycle. The bench provokes this with read bytes whose MSB is 0, where the line stays low straight through from the acknowledge into the data, and with read bytes whose MSB is 1, where the line must be released. It judges the result by the byte it samples on the following SCL highs, and by a monitor that flags any change of `sda_oe` while SCL is high.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int OFF_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } smb_state_e;

endpackage

// File: rtl/smb_sync.sv
// Synchronises SCL and SDA and derives edge and bus-condition pulses.
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_ff[g] <= 1'b1;
                sda_ff[g] <= 1'b1;
            end else begin
                scl_ff[g] <= scl_ff[g-1];
                sda_ff[g] <= sda_ff[g-1];
            end
        end
    end

    assign scl_lvl = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/smb_rx_shift.sv
// Receive shift register with a bit counter; clear wins over sample.
module smb_rx_shift import smb_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic [CNT_W-1:0]  cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o <= '0;
            cnt    <= '0;
        end else if (clr) begin
            cnt    <= '0;
        end else if (sample) begin
            byte_o <= {byte_o[BYTE_W-2:0], bit_in};
            if (cnt != CNT_W'(BYTE_W)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smb_tx_shift.sv
// Transmit shift register: parallel load, shift towards the MSB.
module smb_tx_shift import smb_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] data_in,
    output logic              msb,
    output logic              nxt
);

    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= data_in;
        end else if (shift) begin
            sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
        end
    end

    assign msb = sh_q[BYTE_W-1];
    assign nxt = sh_q[BYTE_W-2];

endmodule

// File: rtl/smb_ctrl.sv
// Transaction state machine: address match, command decode, ack and read data drive.
module smb_ctrl import smb_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic              tx_msb,
    input  logic              tx_nxt,
    output logic              rx_clr,
    output logic              rx_sample,
    output logic              tx_load,
    output logic              tx_shift,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              rd_req,
    output logic [OFF_W-1:0]  reg_off,
    output logic [BYTE_W-1:0] wr_data,
    output smb_state_e        state
);

    smb_state_e        state_q, state_d;
    logic              armed_q;
    logic              is_read_q;
    logic              rd_pend_q;
    logic [BYTE_W-1:0] data_q;

    logic byte_done;
    logic addr_match;
    logic rx_rw;
    logic addr_ok;
    logic in_bits;

    assign byte_done  = (rx_cnt == CNT_W'(BYTE_W));
    assign addr_match = (rx_byte[BYTE_W-1:1] == dev_addr);
    assign rx_rw      = rx_byte[0];
    assign addr_ok    = addr_match && (!rx_rw || armed_q);
    assign in_bits    = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                        (state_q == ST_DATA) || (state_q == ST_TX);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done) state_d = addr_ok ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall) state_d = is_read_q ? ST_TX : ST_CMD;
                ST_CMD:      if (scl_fall && byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) state_d = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_d = ST_HOLD;
                ST_TX:       if (scl_fall && byte_done) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_rise) state_d = ST_HOLD;
                ST_HOLD:     state_d = ST_HOLD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    assign rx_clr    = start_det || (state_d != state_q);
    assign rx_sample = scl_rise && in_bits;
    assign tx_shift  = (state_q == ST_TX) && scl_fall && !byte_done && !start_det && !stop_det;
    assign tx_load   = rd_pend_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            wr_stb    <= 1'b0;
            rd_req    <= 1'b0;
            rd_pend_q <= 1'b0;
            armed_q   <= 1'b0;
            is_read_q <= 1'b0;
            reg_off   <= '0;
            data_q    <= '0;
            wr_data   <= '0;
        end else begin
            wr_stb    <= 1'b0;
            rd_req    <= 1'b0;
            rd_pend_q <= rd_req;
            if (stop_det) begin
                sda_oe    <= 1'b0;
                armed_q   <= 1'b0;
                is_read_q <= 1'b0;
            end else if (start_det) begin
                sda_oe    <= 1'b0;
                is_read_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (scl_fall && byte_done && addr_ok) begin
                            sda_oe    <= 1'b1;
                            is_read_q <= rx_rw;
                            rd_req    <= rx_rw;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= is_read_q ? ~tx_msb : 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (scl_fall && byte_done) begin
                            sda_oe  <= 1'b1;
                            armed_q <= rx_byte[BYTE_W-1];
                            reg_off <= rx_byte[OFF_W-1:0];
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        if (scl_fall && byte_done) begin
                            sda_oe <= 1'b1;
                            data_q <= rx_byte;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (armed_q) begin
                                wr_stb  <= 1'b1;
                                wr_data <= data_q;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            sda_oe <= byte_done ? 1'b0 : ~tx_nxt;
                        end
                    end
                    ST_IDLE, ST_TX_ACK, ST_HOLD: begin
                        sda_oe <= 1'b0;
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/smb_byte_slave.sv
// Top: byte-access register slave on a two-wire management bus.
module smb_byte_slave import smb_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [OFF_W-1:0]  reg_off,
    output logic              reg_wr_stb,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_req,
    input  logic [BYTE_W-1:0] reg_rd_data
);

    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              rx_clr;
    logic              rx_sample;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  rx_cnt;
    logic              tx_load;
    logic              tx_shift;
    logic              tx_msb;
    logic              tx_nxt;
    smb_state_e        fsm_state;

    smb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_rx_shift u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .sample (rx_sample),
        .bit_in (sda_lvl),
        .byte_o (rx_byte),
        .cnt    (rx_cnt)
    );

    smb_tx_shift u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .shift   (tx_shift),
        .data_in (reg_rd_data),
        .msb     (tx_msb),
        .nxt     (tx_nxt)
    );

    smb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rx_byte   (rx_byte),
        .rx_cnt    (rx_cnt),
        .tx_msb    (tx_msb),
        .tx_nxt    (tx_nxt),
        .rx_clr    (rx_clr),
        .rx_sample (rx_sample),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift),
        .sda_oe    (sda_oe),
        .wr_stb    (reg_wr_stb),
        .rd_req    (reg_rd_req),
        .reg_off   (reg_off),
        .wr_data   (reg_wr_data),
        .state     (fsm_state)
    );

endmodule

// File: rtl/smb_byte_slave_chk.sv
// Property checker attached to the slave top.
module smb_byte_slave_chk import smb_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic       rd_req,
    input smb_state_e state
);

    // R7
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R10
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_req));

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

bind smb_byte_slave smb_byte_slave_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_lvl(scl_lvl),
    .sda_oe (sda_oe),
    .wr_stb (reg_wr_stb),
    .rd_req (reg_rd_req),
    .state  (fsm_state)
);

// File: tb/tb_smb_byte_slave.sv
module tb_smb_byte_slave;

    localparam int        Q   = 6;
    localparam logic [6:0] DEV = 7'h2C;
    localparam int        NV  = 12;
    // {read, address, command, data}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 7'h2C, 8'h85, 8'hA5},
        {1'b0, 7'h2C, 8'hFF, 8'h3C},
        {1'b0, 7'h2C, 8'h80, 8'hFF},
        {1'b1, 7'h2C, 8'h85, 8'h00},
        {1'b0, 7'h2C, 8'h81, 8'h5A},
        {1'b1, 7'h2C, 8'h81, 8'h00},
        {1'b1, 7'h2C, 8'hFF, 8'h00},
        {1'b0, 7'h2C, 8'h05, 8'h77},
        {1'b1, 7'h2C, 8'h80, 8'h00},
        {1'b0, 7'h2D, 8'h83, 8'h11},
        {1'b1, 7'h2C, 8'h05, 8'h00},
        {1'b1, 7'h2C, 8'hA0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] reg_off;
    logic       reg_wr_stb;
    logic [7:0] reg_wr_data;
    logic       reg_rd_req;
    logic [7:0] reg_rd_data;

    logic [7:0] bank    [128];
    logic [7:0] exp_mem [128];

    int compared = 0;
    int mismatched = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int viol = 0;
    logic [6:0] last_wr_off;
    logic [7:0] last_wr_data;
    logic [6:0] last_rd_off;
    logic       prev_oe = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus     = ~(m_low | sda_oe);
    assign reg_rd_data = bank[reg_off];

    smb_byte_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_addr    (DEV),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .reg_off     (reg_off),
        .reg_wr_stb  (reg_wr_stb),
        .reg_wr_data (reg_wr_data),
        .reg_rd_req  (reg_rd_req),
        .reg_rd_data (reg_rd_data)
    );

    // External register bank and port monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'(i * 7 + 3);
        end else begin
            if (reg_wr_stb) begin
                bank[reg_off] <= reg_wr_data;
                wr_cnt++;
                last_wr_off  = reg_off;
                last_wr_data = reg_wr_data;
            end
            if (reg_rd_req) begin
                rd_cnt++;
                last_rd_off = reg_off;
            end
            if (m_scl && (sda_oe !== prev_oe)) viol++;
            prev_oe = sda_oe;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; m_scl = 1'b1; wq();
        m_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b0; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        b = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                            output logic k1, output logic k2, output logic k3);
        bus_start();
        send_byte({a, 1'b0}, k1);
        send_byte(c, k2);
        send_byte(d, k3);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] c,
                           output logic k1, output logic k2, output logic k3, output logic [7:0] d);
        bus_start();
        send_byte({a, 1'b0}, k1);
        send_byte(c, k2);
        bus_rstart();
        send_byte({a, 1'b1}, k3);
        recv_byte(d, 1'b1);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic       k1, k2, k3, k4, match, bmode;
        logic [7:0] rdat;
        int         w0, r0;

        for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 7 + 3);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 wr strobe after reset", reg_wr_stb, 0);
        chk("R1 rd request after reset", reg_rd_req, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            match = (VEC[v][22:16] == DEV);
            bmode = VEC[v][15];
            w0 = wr_cnt;
            r0 = rd_cnt;
            if (!VEC[v][23]) begin
                do_write(VEC[v][22:16], VEC[v][15:8], VEC[v][7:0], k1, k2, k3);
                chk("R2 address ack", k1, match);
                chk("R4 command ack", k2, match);
                chk("R3 data ack", k3, match);
                chk("R3 R4 write strobe count", wr_cnt - w0, match && bmode);
                if (match && bmode) begin
                    chk("R3 write offset", last_wr_off, VEC[v][14:8]);
                    chk("R3 write data", last_wr_data, VEC[v][7:0]);
                    exp_mem[VEC[v][14:8]] = VEC[v][7:0];
                end
            end else begin
                do_read(VEC[v][22:16], VEC[v][15:8], k1, k2, k3, rdat);
                chk("R2 address ack", k1, match);
                chk("R4 command ack", k2, match);
                chk("R6 read address ack", k3, match && bmode);
                chk("R6 read request count", rd_cnt - r0, match && bmode);
                if (match && bmode) begin
                    chk("R5 read offset", last_rd_off, VEC[v][14:8]);
                    chk("R5 read data", rdat, exp_mem[VEC[v][14:8]]);
                end
            end
            chk("R10 no write during read / read during write",
                VEC[v][23] ? (wr_cnt - w0) : (rd_cnt - r0), 0);
            wq();
        end

        // R9 extra byte after data
        w0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, k1);
        send_byte(8'h90, k2);
        send_byte(8'h44, k3);
        send_byte(8'h99, k4);
        bus_stop();
        chk("R9 data ack", k3, 1);
        chk("R9 extra byte not acked", k4, 0);
        chk("R9 single strobe", wr_cnt - w0, 1);
        chk("R9 strobe data", last_wr_data, 8'h44);
        exp_mem[7'h10] = 8'h44;
        wq();

        // R8 stop in the middle of the data byte
        w0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, k1);
        send_byte(8'h8A, k2);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        chk("R8 aborted write gives no strobe", wr_cnt - w0, 0);
        chk("R8 released after stop", sda_oe, 0);
        do_write(DEV, 8'h8A, 8'h12, k1, k2, k3);
        chk("R8 next transaction address ack", k1, 1);
        chk("R8 next transaction strobe", wr_cnt - w0, 1);
        chk("R8 next transaction data", last_wr_data, 8'h12);
        exp_mem[7'h0A] = 8'h12;
        wq();

        // R8 repeated start restarts address phase of a write
        w0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, k1);
        send_byte(8'h82, k2);
        bus_rstart();
        send_byte({DEV, 1'b0}, k3);
        send_byte(8'h83, k4);
        send_byte(8'h66, k1);
        bus_stop();
        chk("R8 address ack after repeated start", k3, 1);
        chk("R8 data ack after repeated start", k1, 1);
        chk("R8 strobe after repeated start", wr_cnt - w0, 1);
        chk("R8 offset after repeated start", last_wr_off, 7'h03);
        exp_mem[7'h03] = 8'h66;
        wq();

        // R5 read back of bytes written by directed tests
        do_read(DEV, 8'h83, k1, k2, k3, rdat);
        chk("R5 read back 0x03", rdat, exp_mem[7'h03]);
        do_read(DEV, 8'h90, k1, k2, k3, rdat);
        chk("R5 read back 0x10", rdat, exp_mem[7'h10]);

        chk("R7 no SDA change while SCL high", viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule